// File: doc/BRIEF.md
# Two-Stage Watchdog Interval Timer

This block measures long stretches of time with two cascaded up-counters. A wide base counter advances on every clock while the timer runs. A narrower main counter advances once each time the base counter wraps. Software sets how many base wraps make up one period. When the main counter reaches that count it wraps, and the timer reacts according to the selected mode. In interval mode it sets an interval flag and can pulse an interrupt. In watchdog mode it sets a watchdog flag and holds a reset request for a fixed number of clocks.

Software reaches the block through a small register write port with byte strobes and a combinational read port. Restarting the base counter needs a key byte in the top byte of a full-word write, so a stray narrow store cannot restart it. Writing the limit register loads a new limit and restarts the main counter, which is how software services the watchdog.

A three-state controller sequences the block. The states are ST_HALT, ST_COUNT and ST_PULSE, and it has these transitions:
- halt-to-count: taken when the enable bit is 1.
- count-to-halt: taken when the enable bit is 0.
- count-to-pulse: taken on a main overflow in watchdog mode.
- pulse-to-count: taken after the last pulse cycle when the enable bit is 1.
- pulse-to-halt: taken after the last pulse cycle when the enable bit is 0.

In ST_HALT both counters are held at zero. In ST_PULSE the reset request is driven high.

Top module: `twostage_wdt`

## Requirements
- R1: After reset, all of the following hold until software sets the enable bit:
  - every readable field is zero,
  - `irq` and `rst_req` are low,
  - both counters stay at zero.
- R2: Once running, the base counter (read at address 2, bits BASE_W-1:0) rises by one each clock and wraps from its all-ones value to zero.
- R3: Each base wrap advances the main counter (read at address 1, bits 16+MAIN_W-1:16) by one. With a limit T from 1 to 2^MAIN_W-1, the main counter overflows when it would reach T, and it wraps to zero at that point.
- R4: The overflow period is set by the limit:
  - a limit of 1 gives one overflow every 2^BASE_W clocks,
  - a limit of 0 stands for 2^MAIN_W base wraps, which is one overflow every 2^(BASE_W+MAIN_W) clocks.
- R5: A write to address 2 clears the base counter only when all four strobes are set and wr_data[31:24] is 0x55. A write with any other top byte, or with any strobe missing, leaves the base counter counting on. When a key write and a base wrap fall in the same cycle, the clear wins and the main counter does not advance.
- R6: A write to address 1 with strobes 1:0 both set loads the limit from wr_data[MAIN_W-1:0] and clears the main counter in the same cycle.
- R7: The control register is at address 0 and is written when strobe 0 is set. Its bits are:
  - bit 0: enable,
  - bit 1: mode, where 1 selects watchdog,
  - bit 2: interrupt enable.
  Clearing the enable bit returns both counters to zero and keeps them there.
- R8: In interval mode, each overflow sets the interval flag (address 3, bit 0). If the interrupt enable bit is set, the overflow also raises `irq` for exactly one clock, starting the cycle after the overflow edge.
- R9: In watchdog mode, an overflow sets the watchdog flag (address 3, bit 1) and drives `rst_req` high for exactly PULSE_LEN (16) clocks. An overflow that lands while the pulse is running does not extend it.
- R10: The flags at address 3 are sticky and are written when strobe 0 is set:
  - writing 0 to a flag bit clears it,
  - writing 1 has no effect,
  - if an overflow and a clearing write fall in the same cycle, the flag stays set.
- R11: Reading the control and limit registers returns the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 limit, 2 base key, 3 flags) |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte enables for the write |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| irq | output | 1 | One-clock interval interrupt pulse |
| rst_req | output | 1 | Watchdog reset request |

## Verification
On every cycle, the assertions check the following:
- the length of each reset-request pulse,
- that a watchdog flag stands behind every reset request,
- that the counters are zero after a halted cycle,
- that the main counter stays below a non-zero limit,
- that flags only fall after a clearing write,
- that `irq` never appears without the interval flag.

Only the bench scenarios can show the measured periods for the shortest, a middle and the longest limit. The same holds for the rejection of wrong keys and narrow writes, the restart of the main counter on a limit write, and the precedence of an overflow over a clear that lands in the same cycle.

// File: rtl/twdt_pkg.sv
package twdt_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } twdt_state_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_LIMIT = 2'd1;
    localparam logic [1:0] A_BASE  = 2'd2;
    localparam logic [1:0] A_FLAGS = 2'd3;

    localparam logic [7:0] BASE_KEY = 8'h55;
    localparam int         MAIN_LSB = 16;

endpackage

// File: rtl/twdt_base_cnt.sv
module twdt_base_cnt #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_zero,
    input  logic         count_en,
    input  logic         clear,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    // wrap only when the count really advances past all-ones
    always_comb begin
        wrap = count_en && !clear && (cnt == {W{1'b1}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold_zero || clear) begin
            cnt <= '0;
        end else if (count_en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/twdt_main_cnt.sv
module twdt_main_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_zero,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    logic [W:0] nxt;
    logic [W:0] lim_ext;

    always_comb begin
        nxt     = {1'b0, cnt} + (W+1)'(1);
        // a zero limit stands for the full 2^W span
        lim_ext = (limit == '0) ? {1'b1, {W{1'b0}}} : {1'b0, limit};
        ovf     = step && !clear && !hold_zero && (nxt == lim_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold_zero || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= ovf ? '0 : nxt[W-1:0];
        end
    end

endmodule

// File: rtl/twdt_ctrl_fsm.sv
module twdt_ctrl_fsm
    import twdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    input  logic        wd_ovf,
    output twdt_state_e state,
    output logic        counting,
    output logic        hold_zero,
    output logic        rst_req
);

    localparam int             PCW  = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PCW-1:0] LAST = PCW'(PULSE_LEN - 1);

    twdt_state_e    state_nx;
    logic [PCW-1:0] pulse_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: begin
                if (run_en) state_nx = ST_COUNT;
            end
            ST_COUNT: begin
                if (!run_en)     state_nx = ST_HALT;
                else if (wd_ovf) state_nx = ST_PULSE;
            end
            ST_PULSE: begin
                if (pulse_cnt == LAST) state_nx = run_en ? ST_COUNT : ST_HALT;
            end
            default: state_nx = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
        end else if (state != ST_PULSE) begin
            pulse_cnt <= '0;
        end else begin
            pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    always_comb begin
        hold_zero = (state == ST_HALT);
        counting  = (state != ST_HALT) && run_en;
        rst_req   = (state == ST_PULSE);
    end

endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
    import twdt_pkg::*;
#(
    parameter int BASE_W    = 18,
    parameter int MAIN_W    = 12,
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_strb,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq,
    output logic        rst_req
);

    logic              ctrl_en, ctrl_wd, ctrl_irqen;
    logic [MAIN_W-1:0] limit_q;
    logic              flag_int, flag_wd, irq_q;
    logic [BASE_W-1:0] base_cnt;
    logic [MAIN_W-1:0] main_cnt;
    logic              base_wrap, main_ovf;
    logic              counting, hold_zero;
    logic              wr_ctrl, wr_limit, wr_key, wr_flags;
    twdt_state_e       state;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == A_CTRL)  && wr_strb[0];
        wr_limit = wr_en && (wr_addr == A_LIMIT) && (wr_strb[1:0] == 2'b11);
        wr_key   = wr_en && (wr_addr == A_BASE)  && (wr_strb == 4'hF)
                   && (wr_data[31:24] == BASE_KEY);
        wr_flags = wr_en && (wr_addr == A_FLAGS) && wr_strb[0];
    end

    twdt_base_cnt #(.W(BASE_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (hold_zero),
        .count_en  (counting),
        .clear     (wr_key),
        .cnt       (base_cnt),
        .wrap      (base_wrap)
    );

    twdt_main_cnt #(.W(MAIN_W)) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_zero (hold_zero),
        .clear     (wr_limit),
        .step      (base_wrap),
        .limit     (limit_q),
        .cnt       (main_cnt),
        .ovf       (main_ovf)
    );

    twdt_ctrl_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (ctrl_en),
        .wd_ovf    (main_ovf && ctrl_wd),
        .state     (state),
        .counting  (counting),
        .hold_zero (hold_zero),
        .rst_req   (rst_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            ctrl_wd    <= 1'b0;
            ctrl_irqen <= 1'b0;
            limit_q    <= '0;
            flag_int   <= 1'b0;
            flag_wd    <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en    <= wr_data[0];
                ctrl_wd    <= wr_data[1];
                ctrl_irqen <= wr_data[2];
            end
            if (wr_limit) begin
                limit_q <= wr_data[MAIN_W-1:0];
            end
            // a set from an overflow outranks a clearing write
            flag_int <= (flag_int && !(wr_flags && !wr_data[0])) || (main_ovf && !ctrl_wd);
            flag_wd  <= (flag_wd  && !(wr_flags && !wr_data[1])) || (main_ovf &&  ctrl_wd);
            irq_q    <= main_ovf && !ctrl_wd && ctrl_irqen;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data[2:0] = {ctrl_irqen, ctrl_wd, ctrl_en};
            A_LIMIT: begin
                rd_data[MAIN_W-1:0]          = limit_q;
                rd_data[MAIN_LSB +: MAIN_W]  = main_cnt;
            end
            A_BASE:  rd_data[BASE_W-1:0] = base_cnt;
            default: rd_data[1:0] = {flag_wd, flag_int};
        endcase
    end

    assign irq = irq_q;

endmodule

// File: rtl/twdt_checker.sv
module twdt_checker
    import twdt_pkg::*;
#(
    parameter int BASE_W    = 18,
    parameter int MAIN_W    = 12,
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input twdt_state_e       state,
    input logic [BASE_W-1:0] base_cnt,
    input logic [MAIN_W-1:0] main_cnt,
    input logic [MAIN_W-1:0] limit_q,
    input logic              flag_int,
    input logic              flag_wd,
    input logic              irq,
    input logic              rst_req,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic [3:0]        wr_strb
);

    int  run_len;
    logic clr_int, clr_wd;

    always_comb begin
        clr_int = wr_en && (wr_addr == A_FLAGS) && wr_strb[0] && !wr_data[0];
        clr_wd  = wr_en && (wr_addr == A_FLAGS) && wr_strb[0] && !wr_data[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_len <= 0;
        else if (rst_req) run_len <= run_len + 1;
        else              run_len <= 0;
    end

    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(rst_req) |-> run_len == PULSE_LEN); // R9
    AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_req) |-> flag_wd); // R9
    AST_HALT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_HALT) |=> (base_cnt == '0 && main_cnt == '0)); // R7
    AST_MAIN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (limit_q != '0) |-> (main_cnt < limit_q)); // R3
    AST_INT_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag_int && !clr_int) |=> flag_int); // R10
    AST_WD_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag_wd && !clr_wd) |=> flag_wd); // R10
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> flag_int); // R8

endmodule

bind twostage_wdt twdt_checker #(
    .BASE_W    (BASE_W),
    .MAIN_W    (MAIN_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .base_cnt (base_cnt),
    .main_cnt (main_cnt),
    .limit_q  (limit_q),
    .flag_int (flag_int),
    .flag_wd  (flag_wd),
    .irq      (irq),
    .rst_req  (rst_req),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_strb  (wr_strb)
);

// File: tb/sim_twostage_wdt.sv
`timescale 1ns/1ps
module sim_twostage_wdt;

    localparam int BW   = 4;
    localparam int MW   = 12;
    localparam int PL   = 16;
    localparam int BMAX = (1 << BW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [3:0]  wr_strb = 4'd0;
    logic [1:0]  rd_addr = 2'd2;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    // reference state
    int m_base = 0, m_main = 0, m_lim = 0, m_left = 0;
    bit m_en = 0, m_wd = 0, m_ie = 0, m_fi = 0, m_fw = 0, m_irq = 0, m_run = 0;

    always #10 clk = ~clk;

    twostage_wdt #(.BASE_W(BW), .MAIN_W(MW), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint mrd(input logic [1:0] a);
        case (a)
            2'd0:    return longint'({m_ie, m_wd, m_en});
            2'd1:    return longint'(m_lim) + (longint'(m_main) << 16);
            2'd2:    return longint'(m_base);
            default: return longint'({m_fw, m_fi});
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_main = 0; m_lim = 0; m_left = 0;
            m_en = 0; m_wd = 0; m_ie = 0; m_fi = 0; m_fw = 0; m_irq = 0; m_run = 0;
        end else begin
            int lim, nb, nm;
            bit on, key, thr, ctl, flg, wrap, ovf, nrun;
            lim  = (m_lim == 0) ? (1 << MW) : m_lim;
            on   = m_run && m_en;
            key  = wr_en && wr_addr == 2 && wr_strb == 4'hF && wr_data[31:24] == 8'h55;
            thr  = wr_en && wr_addr == 1 && wr_strb[1:0] == 2'b11;
            ctl  = wr_en && wr_addr == 0 && wr_strb[0];
            flg  = wr_en && wr_addr == 3 && wr_strb[0];
            wrap = on && !key && m_base == BMAX;
            ovf  = 0;
            if (!m_run) begin
                nb = 0; nm = 0;
            end else begin
                nb = key ? 0 : (on ? ((m_base == BMAX) ? 0 : m_base + 1) : m_base);
                nm = m_main;
                if (thr) nm = 0;
                else if (wrap) begin
                    if (m_main + 1 == lim) begin nm = 0; ovf = 1; end
                    else nm = m_main + 1;
                end
            end
            nrun  = m_en || (m_run && m_left > 1);
            m_irq = ovf && !m_wd && m_ie;
            m_fi  = (m_fi && !(flg && !wr_data[0])) || (ovf && !m_wd);
            m_fw  = (m_fw && !(flg && !wr_data[1])) || (ovf && m_wd);
            if (m_left == 0) m_left = (ovf && m_wd) ? PL : 0;
            else             m_left = m_left - 1;
            m_run  = nrun;
            m_base = nb;
            m_main = nm;
            if (ctl) begin m_en = wr_data[0]; m_wd = wr_data[1]; m_ie = wr_data[2]; end
            if (thr) m_lim = int'(wr_data[MW-1:0]);
        end
    end

    // compare a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            string tg;
            chk(irq == m_irq, "R8 irq", irq, m_irq);
            chk(rst_req == (m_left > 0), "R9 rst_req", rst_req, m_left > 0);
            case (rd_addr)
                2'd0: tg = "R11 ctrl";
                2'd1: tg = "R3 main/limit";
                2'd2: tg = "R2 base";
                default: tg = "R10 flags";
            endcase
            chk(longint'(rd_data) == mrd(rd_addr), tg, rd_data, mrd(rd_addr));
        end
    end

    // caller is just past a falling edge; returns on the next one
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = 4'd0;
    endtask

    task automatic rd(input logic [1:0] a, output longint v);
        rd_addr = a;
        #1;
        v = longint'(rd_data);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!irq && n < 100000);
    endtask

    initial begin
        longint v, b;
        int n;
        repeat (3) @(negedge clk);
        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1 reset read", v, 0);
        end
        chk(irq == 0 && rst_req == 0, "R1 outputs", {irq, rst_req}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd2, v);
        chk(v == 0, "R1 held before enable", v, 0);

        // R4 shortest period, R11 readback
        @(negedge clk);
        wr(2'd1, 32'd1, 4'h3);
        wr(2'd0, 32'd5, 4'h1);
        rd(2'd0, v);
        chk(v == 5, "R11 ctrl readback", v, 5);
        rd(2'd1, v);
        chk((v & 32'hFFF) == 1, "R11 limit readback", v & 32'hFFF, 1);
        rd_addr = 2'd2;
        wait_irq(n);
        wait_irq(n);
        chk(n == (1 << BW), "R4 period limit 1", n, 1 << BW);

        // R3 middle limit
        wr(2'd1, 32'd5, 4'h3);
        wait_irq(n);
        wait_irq(n);
        chk(n == 5 * (1 << BW), "R3 period limit 5", n, 5 * (1 << BW));

        // R2 step, R5 key handling
        rd(2'd2, b);
        @(negedge clk);
        rd(2'd2, v);
        chk(v == ((b + 1) & BMAX), "R2 base step", v, (b + 1) & BMAX);
        b = v;
        wr(2'd2, 32'h5400_0000, 4'hF);
        rd(2'd2, v);
        chk(v == ((b + 1) & BMAX), "R5 wrong key ignored", v, (b + 1) & BMAX);
        b = v;
        wr(2'd2, 32'h5500_0000, 4'h8);
        rd(2'd2, v);
        chk(v == ((b + 1) & BMAX), "R5 narrow write ignored", v, (b + 1) & BMAX);
        wr(2'd2, 32'h5500_0000, 4'hF);
        rd(2'd2, v);
        chk(v == 0, "R5 key clears base", v, 0);

        // R6 limit write clears main
        n = 0;
        do begin @(negedge clk); rd(2'd1, v); n++; end while (((v >> 16) & 32'hFFF) == 0 && n < 200);
        wr(2'd1, 32'd5, 4'h3);
        rd(2'd1, v);
        chk(((v >> 16) & 32'hFFF) == 0, "R6 main cleared", (v >> 16) & 32'hFFF, 0);

        // R10 flag rules
        @(negedge clk);
        wr(2'd3, 32'h3, 4'h1);
        rd(2'd3, v);
        chk(v[0] == 1, "R10 write one keeps flag", v[0], 1);
        while (!(m_base == BMAX && m_main + 1 == 5)) @(negedge clk);
        wr(2'd3, 32'h0, 4'h1);
        rd(2'd3, v);
        chk(v[0] == 1, "R10 set beats clear", v[0], 1);
        wr(2'd3, 32'h0, 4'h1);
        rd(2'd3, v);
        chk(v[0] == 0, "R10 write zero clears", v[0], 0);

        // R9 watchdog pulse
        wr(2'd0, 32'd3, 4'h1);
        wr(2'd1, 32'd3, 4'h3);
        rd_addr = 2'd3;
        n = 0;
        while (!rst_req && n < 1000) begin @(negedge clk); n++; end
        n = 0;
        while (rst_req && n < 100) begin n++; @(negedge clk); end
        chk(n == PL, "R9 pulse length", n, PL);
        rd(2'd3, v);
        chk(v[1] == 1, "R9 watchdog flag", v[1], 1);

        // R7 disable holds counters at zero
        @(negedge clk);
        wr(2'd0, 32'd0, 4'h1);
        repeat (2) @(negedge clk);
        rd(2'd2, v);
        chk(v == 0, "R7 base zero when off", v, 0);
        repeat (5) @(negedge clk);
        rd(2'd1, v);
        chk(((v >> 16) & 32'hFFF) == 0, "R7 main zero when off", (v >> 16) & 32'hFFF, 0);

        // R4 longest period
        @(negedge clk);
        wr(2'd1, 32'd0, 4'h3);
        wr(2'd0, 32'd5, 4'h1);
        rd_addr = 2'd2;
        wait_irq(n);
        wait_irq(n);
        chk(n == (1 << (BW + MW)), "R4 period limit 0", n, 1 << (BW + MW));

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nbad++;
            $display("FAIL R1 watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule